// File: doc/BRIEF.md
# Reloading terminal-count strobe counter

This block is an unsigned up-counter that emits a single-cycle strobe each time its count reaches a programmable terminal value. The strobe reloads the count to 1 on the following clock. The block is meant for the fastest clock of a design. The enable goes straight into the carry-in of the incrementer, so no hold multiplexer sits in front of the count register. The terminal value also passes through a staging register before the comparator, which keeps the input wiring off the compare path.

A typical use is a programmable tick or rate divider. The terminal value sets how many enabled cycles pass between strobes. Enable low pauses the count but does not delay a pending reload.

Top module: `strobe_reload_counter`

## Requirements
- R1: At power-up, before any clock edge, the count is 0 and the strobe is 0.
- R2: If rst_n is low at a rising edge, the next cycle shows count 1 and strobe 0, whatever the enable and count were.
- R3: With rst_n high, strobe low and enable high, the count rises by exactly 1 per clock and wraps from 0xFFFF to 0x0000. With enable low it holds its value.
- R4: With rst_n high, strobe low and enable high, if the count is greater than or equal to the staged terminal value (unsigned), the strobe is high in the next cycle.
- R5: The strobe lasts exactly one cycle. The cycle after a strobe shows count 1 and strobe 0, whether enable is high or low.
- R6: When the count climbs to the terminal value T, the count shown during the strobe cycle is T+1 modulo 2^16. From reload, a strobe therefore takes T enabled cycles, plus the strobe cycle itself.
- R7: The comparator sees the terminal input sampled at the previous rising edge. A new terminal value therefore first affects the strobe decision one clock after it is applied.
- R8: If the staged terminal value is at or below the current count, including terminal value 0, the next enabled cycle raises the strobe.
- R9: The strobe never rises in a cycle that follows a clock with enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset, reloads the count to 1 |
| en | input | 1 | Count enable, used as incrementer carry-in |
| term_in | input | 16 | Terminal value, unsigned |
| strobe | output | 1 | One-cycle terminal strobe |
| count | output | 16 | Current count |

## Verification
The hardest situation to reach is the wrap of the top terminal value 0xFFFF. There the count must climb through every value and show 0x0000 during the strobe, and that takes about 65 thousand enabled cycles. The stimulus holds enable high for seven cycles in eight until that strobe and its reload have passed. A second hard situation is lowering the terminal value below a count that is already running. The bench reaches it by counting past 100 against a large terminal, then lowering the terminal to 50. The strobe must follow exactly one staging clock later.

// File: rtl/strobe_reload_counter_pkg.sv
package strobe_reload_counter_pkg;
    localparam int unsigned DEF_CNT_W = 16;

    // value loaded by reset and by the strobe
    function automatic logic [DEF_CNT_W-1:0] reload_value();
        return DEF_CNT_W'(1);
    endfunction
endpackage

// File: rtl/src_carry_inc.sv
module src_carry_inc #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] carry;

    assign carry[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign sum[i]      = a[i] ^ carry[i];
        assign carry[i+1]  = a[i] & carry[i];
    end

    assign cout = carry[W];
endmodule

// File: rtl/src_ge_cmp.sv
module src_ge_cmp #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] lhs,
    input  logic [W-1:0] rhs,
    output logic         ge
);
    // lhs >= rhs  <=>  carry out of lhs + ~rhs + 1
    logic [W:0] carry;

    assign carry[0] = 1'b1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign carry[i+1] = (lhs[i] & ~rhs[i]) | (lhs[i] & carry[i]) | (~rhs[i] & carry[i]);
    end

    assign ge = carry[W];
endmodule

// File: rtl/src_term_stage.sv
module src_term_stage #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic [W-1:0] term_d,
    output logic [W-1:0] term_q
);
    logic [W-1:0] stage_q = '0;

    always_ff @(posedge clk) begin
        stage_q <= term_d;
    end

    assign term_q = stage_q;
endmodule

// File: rtl/strobe_reload_counter.sv
module strobe_reload_counter
    import strobe_reload_counter_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] term_in,
    output logic             strobe,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             stb;
    } state_t;

    state_t state_d;
    state_t state_q = '0;

    logic [CNT_W-1:0] term_q;
    logic [CNT_W-1:0] inc_sum;
    logic             inc_cout;
    logic             at_term;

    src_term_stage #(.W(CNT_W)) u_term (
        .clk    (clk),
        .term_d (term_in),
        .term_q (term_q)
    );

    src_carry_inc #(.W(CNT_W)) u_inc (
        .a    (state_q.cnt),
        .cin  (en),
        .sum  (inc_sum),
        .cout (inc_cout)
    );

    src_ge_cmp #(.W(CNT_W)) u_cmp (
        .lhs (state_q.cnt),
        .rhs (term_q),
        .ge  (at_term)
    );

    always_comb begin
        state_d     = state_q;
        state_d.cnt = inc_sum;
        state_d.stb = en & at_term;
        if (!rst_n || state_q.stb) begin
            state_d.cnt = RELOAD;
            state_d.stb = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign strobe = state_q.stb;
    assign count  = state_q.cnt;

    logic unused_cout;
    assign unused_cout = inc_cout;
endmodule

// File: rtl/strobe_reload_counter_chk.sv
module strobe_reload_counter_chk #(
    parameter int unsigned W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en,
    input logic [W-1:0] term_in,
    input logic [W-1:0] term_stage,
    input logic         strobe,
    input logic [W-1:0] count
);
    logic past_ok = 1'b0;
    always_ff @(posedge clk) past_ok <= 1'b1;

    a_r2_reset_reload: assert property (@(posedge clk) disable iff (!past_ok)
        !rst_n |=> (count == W'(1)) && !strobe);

    a_r5_single_strobe: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
        strobe |=> !strobe && (count == W'(1)));

    a_r3_increment: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
        (en && !strobe) |=> count == W'($past(count) + W'(1)));

    a_r3_hold: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
        (!en && !strobe) |=> $stable(count));

    a_r4_strobe_at_term: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
        (en && !strobe && (count >= term_stage)) |=> strobe);

    a_r9_idle_no_strobe: assert property (@(posedge clk) disable iff (!past_ok || !rst_n)
        (!en) |=> !strobe);

    a_r7_term_staged: assert property (@(posedge clk) disable iff (!past_ok)
        1'b1 |=> term_stage == $past(term_in));
endmodule

bind strobe_reload_counter strobe_reload_counter_chk #(.W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .term_in    (term_in),
    .term_stage (term_q),
    .strobe     (strobe),
    .count      (count)
);

// File: tb/strobe_reload_counter_bench.sv
`timescale 1ns/1ps
module strobe_reload_counter_bench;
    localparam int W = 16;

    typedef struct {
        logic [W-1:0] cnt;
        logic         stb;
        string        tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         en = 1'b0;
    logic [W-1:0] term_in = '0;
    logic         strobe;
    logic [W-1:0] count;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    exp_t sb_q[$];

    // reference state
    logic [W-1:0] m_cnt   = '0;
    logic         m_stb   = 1'b0;
    logic [W-1:0] m_termq = '0;
    string        extra_tag = "";

    always #10 clk = ~clk;

    strobe_reload_counter u_strobe_reload_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .term_in (term_in),
        .strobe  (strobe),
        .count   (count)
    );

    task automatic step(input logic r, input logic e, input logic [W-1:0] t);
        exp_t it;
        @(negedge clk);
        rst_n   = r;
        en      = e;
        term_in = t;
        if (!r) begin
            it.tag = "R2"; it.cnt = W'(1); it.stb = 1'b0;
        end else if (m_stb) begin
            it.tag = "R5"; it.cnt = W'(1); it.stb = 1'b0;
        end else if (e) begin
            it.cnt = m_cnt + W'(1);
            it.stb = (m_cnt >= m_termq);
            it.tag = it.stb ? "R4 R6 R8" : "R3";
        end else begin
            it.tag = "R3 R9"; it.cnt = m_cnt; it.stb = 1'b0;
        end
        it.tag  = {it.tag, extra_tag};
        m_cnt   = it.cnt;
        m_stb   = it.stb;
        m_termq = t;
        sb_q.push_back(it);
    endtask

    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            vectors++;
            if (count !== it.cnt || strobe !== it.stb) begin
                errors++;
                $display("FAIL %s: count=%h strobe=%b expected count=%h strobe=%b",
                         it.tag, count, strobe, it.cnt, it.stb);
            end
        end
    end

    task automatic run_random(input logic [W-1:0] t, input int n, input int low_in);
        for (int i = 0; i < n; i++) step(1'b1, ($urandom % low_in) != 0, t);
    endtask

    initial begin
        #1;
        vectors++;
        if (count !== '0 || strobe !== 1'b0) begin
            errors++;
            $display("FAIL R1: count=%h strobe=%b expected count=0000 strobe=0", count, strobe);
        end

        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, W'(1));

        // T = 1 and T = 2 with random enable (R4 R5 R6 R9)
        run_random(W'(1), 300, 2);
        run_random(W'(2), 300, 2);

        // T = 0 (R8)
        extra_tag = " R8";
        run_random(W'(0), 60, 3);

        // lower terminal below running count (R7 R8)
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, W'(1000));
        for (int i = 0; i < 120; i++) step(1'b1, 1'b1, W'(1000));
        extra_tag = " R7";
        step(1'b1, 1'b1, W'(50));
        step(1'b1, 1'b1, W'(50));
        step(1'b1, 1'b0, W'(50));
        step(1'b1, 1'b1, W'(50));

        // reset overrides counting and a pending strobe (R2)
        extra_tag = " R2";
        run_random(W'(5), 20, 4);
        step(1'b1, 1'b1, W'(0));
        step(1'b0, 1'b1, W'(0));
        step(1'b1, 1'b1, W'(0));
        step(1'b0, 1'b1, W'(0));
        step(1'b0, 1'b1, W'(0));

        // T = 0xFFFF, wrap shown during strobe (R3 R6)
        extra_tag = " R6";
        run_random(W'(16'hFFFF), 76000, 8);
        while (m_stb || m_cnt != W'(1)) step(1'b1, 1'b1, W'(16'hFFFF));
        step(1'b1, 1'b1, W'(16'hFFFF));
        step(1'b1, 1'b1, W'(16'hFFFF));

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                errors++;
                $display("FAIL watchdog: run did not complete, expected completion");
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule